// File: doc/BRIEF.md
# Multi-format audio serial port

This block is the master side of a stereo serial audio link to an external converter pair. Its clock is the master audio clock, so it runs at 256 or 384 times the frame rate. From that clock it generates the bit clock and the frame-sync clock for the converters. Every frame is 64 bit-clock periods long. The first 32-slot half carries the left sample and the second half carries the right sample. Playback pairs arrive on a parallel valid/ready port and go out serially, most significant bit first. Capture pairs are shifted in from the converter's data line and are handed back on a second valid/ready port.

Three configuration inputs are held static while the block is out of reset. They select the placement of the data within each half (I2S, left-justified or right-justified), the sample width (16, 18, 20 or 24 bits) and the master clock ratio. Playback samples are taken from the low bits of the input words. Capture samples are returned right-aligned with zero fill. When no playback pair is offered at a frame boundary, the port sends the previous pair again and flags an underrun.

Top module: `audio_serial_port`

## Requirements
- R1: With ratio_i=0 the bit clock period is 4 master clocks, and with ratio_i=1 it is 6. Each period is low for the first half and high for the second half, and a frame holds 64 bit-clock periods.
- R2: res_i selects the sample width: 0=16, 1=18, 2=20, 3=24 bits. Playback uses bits [n-1:0] of each input word. Capture words are returned right-aligned with every bit above n-1 at zero.
- R3: The frame-sync clock changes only when the bit clock falls. It holds one level for slots 0-31 (left) and the other level for slots 32-63 (right). The left level is low for fmt_i=0 and high for every other fmt_i.
- R4: With fmt_i=0 (I2S) the MSB of each channel sits in slot 1 of its half, followed by the lower bits in the next slots.
- R5: With fmt_i=1 (left-justified) the MSB sits in slot 0 of each half. fmt_i=3 behaves the same way.
- R6: With fmt_i=2 (right-justified) the LSB sits in slot 31 of each half, so the MSB sits in slot 32-n.
- R7: Slots outside the n-bit window drive sdout_o low, and the value of sdin_i in those slots has no effect on the captured word.
- R8: sdout_o changes only when the bit clock falls. sdin_i is sampled on the master clock edge that raises the bit clock.
- R9: tx_ready_o is high for exactly one master cycle per frame: the last master cycle of slot 63. A pair accepted then is sent in the frame that follows. If tx_valid_i is low in that cycle, the held pair is sent again and underrun_o is high for the next master cycle.
- R10: After each complete frame (not the partial frame after reset), rx_valid_o rises with that frame's pair on the rx outputs. The pair stays unchanged until rx_ready_i is seen high or the next frame replaces it.
- R11: While rst_ni is low, bclk_o, lrclk_o, sdout_o, tx_ready_o, underrun_o and rx_valid_o are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master audio clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fmt_i | input | 2 | Framing format: 0 I2S, 1 left-justified, 2 right-justified, 3 as 1 |
| res_i | input | 2 | Sample width code: 16/18/20/24 bits |
| ratio_i | input | 1 | 0: 256x master clock, 1: 384x |
| bclk_o | output | 1 | Bit clock |
| lrclk_o | output | 1 | Frame-sync clock |
| sdout_o | output | 1 | Playback serial data to the DAC |
| sdin_i | input | 1 | Capture serial data from the ADC |
| tx_valid_i | input | 1 | Playback pair offered |
| tx_ready_o | output | 1 | Playback pair taken this cycle |
| tx_left_i | input | SAMPLE_W | Left playback sample |
| tx_right_i | input | SAMPLE_W | Right playback sample |
| underrun_o | output | 1 | One-cycle pulse: previous pair repeated |
| rx_valid_o | output | 1 | Capture pair available |
| rx_ready_i | input | 1 | Capture pair consumed |
| rx_left_o | output | SAMPLE_W | Left capture sample |
| rx_right_o | output | SAMPLE_W | Right capture sample |

## Verification
The assertions assume that fmt_i, res_i and ratio_i change only while rst_ni is low. They also assume that sdin_i is settled before the rising edge of the bit clock. The stimulus meets both assumptions. It changes the configuration only inside a reset pulse. It drives sdin_i one master half-cycle after it sees the bit clock fall, so the level has at least one master cycle to settle before the sampling edge. The playback driver holds tx_valid_i and the data steady from the moment they are offered until the cycle after tx_ready_o. The consumer drops rx_ready_i for much less than one frame, so no captured pair is ever overwritten before it is read.

// File: rtl/asp_pkg.sv
package asp_pkg;
  localparam int FRAME_SLOTS = 64;
  localparam int HALF_SLOTS  = FRAME_SLOTS / 2;
  localparam int SLOT_W      = $clog2(FRAME_SLOTS);
  localparam int POS_W       = $clog2(HALF_SLOTS);

  typedef enum logic [1:0] {
    FMT_I2S = 2'd0,
    FMT_LJ  = 2'd1,
    FMT_RJ  = 2'd2,
    FMT_LJ2 = 2'd3
  } fmt_e;

  typedef struct packed {
    logic             hit;
    logic [POS_W-1:0] idx;
  } win_t;

  function automatic logic [POS_W:0] res_bits(logic [1:0] code);
    case (code)
      2'd0:    return (POS_W+1)'(16);
      2'd1:    return (POS_W+1)'(18);
      2'd2:    return (POS_W+1)'(20);
      default: return (POS_W+1)'(24);
    endcase
  endfunction

  // map a position inside a half-frame to a sample bit index
  function automatic win_t slot_window(fmt_e fmt, logic [1:0] res, logic [POS_W-1:0] pos);
    win_t w;
    logic [POS_W:0] n, off, p, rel;
    n = res_bits(res);
    p = {1'b0, pos};
    case (fmt)
      FMT_I2S: off = (POS_W+1)'(1);
      FMT_RJ:  off = (POS_W+1)'(HALF_SLOTS) - n;
      default: off = '0;
    endcase
    rel   = p - off;
    w.hit = (p >= off) && (p < off + n);
    w.idx = POS_W'(n - (POS_W+1)'(1) - rel);
    return w;
  endfunction
endpackage

// File: rtl/asp_clkgen.sv
module asp_clkgen
  import asp_pkg::*;
#(
  parameter int DIV_LO = 4,
  parameter int DIV_HI = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ratio_i,
  input  fmt_e              fmt_i,
  output logic              bclk_o,
  output logic              lrclk_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic [SLOT_W-1:0] next_slot_o,
  output logic              fall_tick_o,
  output logic              rise_tick_o,
  output logic              frame_tick_o
);
  localparam int CNT_W = $clog2(DIV_HI);

  logic [CNT_W-1:0]  cnt_q, top_cnt, rise_cnt;
  logic [SLOT_W-1:0] slot_q;
  logic              left_lvl;

  assign top_cnt  = ratio_i ? CNT_W'(DIV_HI - 1)     : CNT_W'(DIV_LO - 1);
  assign rise_cnt = ratio_i ? CNT_W'(DIV_HI / 2 - 1) : CNT_W'(DIV_LO / 2 - 1);

  assign fall_tick_o  = (cnt_q == top_cnt);
  assign rise_tick_o  = (cnt_q == rise_cnt);
  assign next_slot_o  = slot_q + SLOT_W'(1);
  assign frame_tick_o = fall_tick_o && (slot_q == SLOT_W'(FRAME_SLOTS - 1));
  assign slot_o       = slot_q;
  assign left_lvl     = (fmt_i != FMT_I2S);

  // reset parks in the last slot so the first fall opens frame slot 0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      slot_q  <= SLOT_W'(FRAME_SLOTS - 1);
      bclk_o  <= 1'b0;
      lrclk_o <= 1'b0;
    end else if (fall_tick_o) begin
      cnt_q   <= '0;
      slot_q  <= next_slot_o;
      bclk_o  <= 1'b0;
      lrclk_o <= next_slot_o[SLOT_W-1] ? ~left_lvl : left_lvl;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
      if (rise_tick_o) bclk_o <= 1'b1;
    end
  end

  p_lrclk_on_fall_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(lrclk_o) |-> $fell(bclk_o));

  p_tick_order_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bclk_o) |-> !fall_tick_o);
endmodule

// File: rtl/asp_tx.sv
module asp_tx
  import asp_pkg::*;
#(
  parameter int SAMPLE_W = 24
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  fmt_e                fmt_i,
  input  logic [1:0]          res_i,
  input  logic                fall_tick_i,
  input  logic                frame_tick_i,
  input  logic [SLOT_W-1:0]   next_slot_i,
  input  logic                tx_valid_i,
  input  logic [SAMPLE_W-1:0] tx_left_i,
  input  logic [SAMPLE_W-1:0] tx_right_i,
  output logic                tx_ready_o,
  output logic                sdout_o,
  output logic                underrun_o
);
  logic [SAMPLE_W-1:0] hold_l_q, hold_r_q, hold_l_n, hold_r_n, word;
  logic                take, bit_n;
  win_t                win;

  assign tx_ready_o = frame_tick_i;
  assign take       = frame_tick_i && tx_valid_i;

  always_comb begin
    hold_l_n = take ? tx_left_i  : hold_l_q;
    hold_r_n = take ? tx_right_i : hold_r_q;
    win      = slot_window(fmt_i, res_i, next_slot_i[POS_W-1:0]);
    word     = next_slot_i[SLOT_W-1] ? hold_r_n : hold_l_n;
    bit_n    = win.hit ? word[win.idx] : 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_l_q   <= '0;
      hold_r_q   <= '0;
      sdout_o    <= 1'b0;
      underrun_o <= 1'b0;
    end else begin
      underrun_o <= frame_tick_i && !tx_valid_i;
      if (take) begin
        hold_l_q <= tx_left_i;
        hold_r_q <= tx_right_i;
      end
      if (fall_tick_i) sdout_o <= bit_n;
    end
  end

  p_underrun_src_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underrun_o |-> $past(tx_ready_o) && !$past(tx_valid_i));

  p_sdout_on_fall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sdout_o) |-> $past(fall_tick_i));
endmodule

// File: rtl/asp_rx.sv
module asp_rx
  import asp_pkg::*;
#(
  parameter int SAMPLE_W = 24
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  fmt_e                fmt_i,
  input  logic [1:0]          res_i,
  input  logic                rise_tick_i,
  input  logic                frame_tick_i,
  input  logic [SLOT_W-1:0]   slot_i,
  input  logic                sdin_i,
  input  logic                rx_ready_i,
  output logic                rx_valid_o,
  output logic [SAMPLE_W-1:0] rx_left_o,
  output logic [SAMPLE_W-1:0] rx_right_o
);
  logic [SAMPLE_W-1:0] sh_l_q, sh_r_q, mask;
  logic [POS_W:0]      n;
  logic                seen_q;
  win_t                win;

  always_comb begin
    n   = res_bits(res_i);
    win = slot_window(fmt_i, res_i, slot_i[POS_W-1:0]);
    for (int i = 0; i < SAMPLE_W; i++) mask[i] = (i < int'(n));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_l_q     <= '0;
      sh_r_q     <= '0;
      seen_q     <= 1'b0;
      rx_valid_o <= 1'b0;
      rx_left_o  <= '0;
      rx_right_o <= '0;
    end else begin
      if (rise_tick_i && win.hit) begin
        if (slot_i[SLOT_W-1]) sh_r_q <= {sh_r_q[SAMPLE_W-2:0], sdin_i};
        else                  sh_l_q <= {sh_l_q[SAMPLE_W-2:0], sdin_i};
      end
      if (frame_tick_i) seen_q <= 1'b1;
      // first boundary after reset closes a partial frame: drop it
      if (frame_tick_i && seen_q) begin
        rx_valid_o <= 1'b1;
        rx_left_o  <= sh_l_q & mask;
        rx_right_o <= sh_r_q & mask;
      end else if (rx_ready_i) begin
        rx_valid_o <= 1'b0;
      end
    end
  end

  p_rx_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o && !rx_ready_i && !frame_tick_i |=>
      rx_valid_o && $stable(rx_left_o) && $stable(rx_right_o));

  p_rx_zero_fill_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> ((rx_left_o | rx_right_o) & ~mask) == '0);
endmodule

// File: rtl/audio_serial_port.sv
module audio_serial_port
  import asp_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int DIV_LO   = 4,
  parameter int DIV_HI   = 6
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [1:0]          fmt_i,
  input  logic [1:0]          res_i,
  input  logic                ratio_i,
  output logic                bclk_o,
  output logic                lrclk_o,
  output logic                sdout_o,
  input  logic                sdin_i,
  input  logic                tx_valid_i,
  output logic                tx_ready_o,
  input  logic [SAMPLE_W-1:0] tx_left_i,
  input  logic [SAMPLE_W-1:0] tx_right_i,
  output logic                underrun_o,
  output logic                rx_valid_o,
  input  logic                rx_ready_i,
  output logic [SAMPLE_W-1:0] rx_left_o,
  output logic [SAMPLE_W-1:0] rx_right_o
);
  fmt_e              fmt;
  logic [SLOT_W-1:0] slot, next_slot;
  logic              fall_tick, rise_tick, frame_tick;

  assign fmt = fmt_e'(fmt_i);

  asp_clkgen #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) u_clkgen (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ratio_i      (ratio_i),
    .fmt_i        (fmt),
    .bclk_o       (bclk_o),
    .lrclk_o      (lrclk_o),
    .slot_o       (slot),
    .next_slot_o  (next_slot),
    .fall_tick_o  (fall_tick),
    .rise_tick_o  (rise_tick),
    .frame_tick_o (frame_tick)
  );

  asp_tx #(.SAMPLE_W(SAMPLE_W)) u_tx (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fmt_i        (fmt),
    .res_i        (res_i),
    .fall_tick_i  (fall_tick),
    .frame_tick_i (frame_tick),
    .next_slot_i  (next_slot),
    .tx_valid_i   (tx_valid_i),
    .tx_left_i    (tx_left_i),
    .tx_right_i   (tx_right_i),
    .tx_ready_o   (tx_ready_o),
    .sdout_o      (sdout_o),
    .underrun_o   (underrun_o)
  );

  asp_rx #(.SAMPLE_W(SAMPLE_W)) u_rx (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fmt_i        (fmt),
    .res_i        (res_i),
    .rise_tick_i  (rise_tick),
    .frame_tick_i (frame_tick),
    .slot_i       (slot),
    .sdin_i       (sdin_i),
    .rx_ready_i   (rx_ready_i),
    .rx_valid_o   (rx_valid_o),
    .rx_left_o    (rx_left_o),
    .rx_right_o   (rx_right_o)
  );

  p_ready_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_ready_o |=> !tx_ready_o);
endmodule

// File: tb/tb_audio_serial_port.sv
module tb_audio_serial_port;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [1:0]  fmt = 2'd0, res = 2'd3;
  logic        ratio = 1'b0;
  logic        bclk, lrclk, sdout;
  logic        sdin = 1'b0;
  logic        tx_valid = 1'b0, tx_ready, underrun, rx_valid;
  logic        rx_ready = 1'b1;
  logic [23:0] tx_l = '0, tx_r = '0, rx_l, rx_r;

  audio_serial_port dut (
    .clk_i(clk), .rst_ni(rst_n), .fmt_i(fmt), .res_i(res), .ratio_i(ratio),
    .bclk_o(bclk), .lrclk_o(lrclk), .sdout_o(sdout), .sdin_i(sdin),
    .tx_valid_i(tx_valid), .tx_ready_o(tx_ready), .tx_left_i(tx_l), .tx_right_i(tx_r),
    .underrun_o(underrun), .rx_valid_o(rx_valid), .rx_ready_i(rx_ready),
    .rx_left_o(rx_l), .rx_right_o(rx_r)
  );

  int checks = 0, errors = 0;
  int n_bits = 24, div = 4, cur_fmt = 0;
  logic [23:0] q_tx_l[$], q_tx_r[$], q_rx_l[$], q_rx_r[$];
  logic [23:0] last_l, last_r, cur_l, cur_r, rxf_l, rxf_r;
  int  bslot, per_cnt, hi_cnt, frame_err, rx_frames;
  bit  framing, bprev, und_pend, und_exp, sd_rise;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int bit_index(int f, int n, int s);
    int p, off;
    p   = s % 32;
    off = (f == 0) ? 1 : ((f == 2) ? 32 - n : 0);
    if (p >= off && p < off + n) return n - 1 - (p - off);
    return -1;
  endfunction

  function automatic logic [23:0] low_mask(int n);
    return 24'((33'd1 << n) - 33'd1);
  endfunction

  function automatic string data_tag(int f);
    if (f == 0) return "R4";
    if (f == 2) return "R6";
    return "R5";
  endfunction

  // monitor / converter model, away from the active edge
  always @(negedge clk) begin
    if (!rst_n) begin
      bslot = 63; framing = 0; bprev = 0; per_cnt = 0; hi_cnt = 0; frame_err = 0;
      und_pend = 0; und_exp = 0; last_l = '0; last_r = '0; cur_l = '0; cur_r = '0;
      rx_frames = 0; sdin = 1'b0;
      q_tx_l.delete(); q_tx_r.delete(); q_rx_l.delete(); q_rx_r.delete();
    end else begin
      per_cnt++;
      if (bclk) hi_cnt++;
      if (und_pend) begin
        chk(underrun == und_exp, "R9", "underrun pulse", int'(underrun), int'(und_exp));
        und_pend = 0;
      end
      if (tx_ready) begin
        if (tx_valid) begin last_l = tx_l; last_r = tx_r; end
        q_tx_l.push_back(last_l); q_tx_r.push_back(last_r);
        und_exp = !tx_valid; und_pend = 1;
      end
      if (rx_valid && rx_ready) begin
        if (q_rx_l.size() == 0) chk(0, "R10", "capture with nothing expected", 1, 0);
        else begin
          logic [23:0] el, er;
          el = q_rx_l.pop_front(); er = q_rx_r.pop_front();
          chk(rx_l == el, {data_tag(cur_fmt), " R2 R7"}, "capture left", int'(rx_l), int'(el));
          chk(rx_r == er, {data_tag(cur_fmt), " R2 R7"}, "capture right", int'(rx_r), int'(er));
        end
      end
      if (!bclk && bprev) begin
        if (framing)
          chk(per_cnt == div && hi_cnt == div / 2, "R1", "bit clock period/high",
              per_cnt * 16 + hi_cnt, div * 16 + div / 2);
        per_cnt = 0; hi_cnt = 0;
        bslot = (bslot + 1) % 64;
        if (bslot == 0) begin
          framing = 1;
          rxf_l = 24'(rx_frames * 32'h9E37 + 32'h51A3C7);
          rxf_r = 24'((rx_frames * 32'h3B1D) ^ 32'hC3A5F0);
          q_rx_l.push_back(rxf_l & low_mask(n_bits));
          q_rx_r.push_back(rxf_r & low_mask(n_bits));
          rx_frames++;
        end
        begin
          int ix;
          ix = bit_index(cur_fmt, n_bits, bslot);
          if (ix < 0) sdin = 1'($urandom_range(0, 1));
          else sdin = (bslot < 32) ? rxf_l[ix] : rxf_r[ix];
        end
      end else if (bclk && !bprev && framing) begin
        int ix;
        logic eb;
        if (bslot == 0) begin
          frame_err = 0;
          if (q_tx_l.size() == 0) chk(0, "R9", "playback frame not expected", 0, 1);
          else begin cur_l = q_tx_l.pop_front(); cur_r = q_tx_r.pop_front(); end
        end
        if (bslot == 0 || bslot == 32) begin
          logic el;
          el = (bslot < 32) ? (cur_fmt != 0) : (cur_fmt == 0);
          chk(lrclk == el, "R3", "frame-sync level", int'(lrclk), int'(el));
        end
        ix = bit_index(cur_fmt, n_bits, bslot);
        eb = (ix < 0) ? 1'b0 : ((bslot < 32) ? cur_l[ix] : cur_r[ix]);
        if (sdout != eb) frame_err++;
        sd_rise = sdout;
        if (bslot == 63)
          chk(frame_err == 0, {data_tag(cur_fmt), " R7 R8"}, "playback frame bit errors",
              frame_err, 0);
      end else if (bclk && bprev && framing) begin
        if (sdout != sd_rise) frame_err++;  // R8: stable while bit clock high
      end
      bprev = bclk;
    end
  end

  task automatic send(logic [23:0] l, logic [23:0] r);
    tx_l = l; tx_r = r; tx_valid = 1'b1;
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    @(posedge clk); #1 tx_valid = 1'b0;
  endtask

  task automatic idle_frame();
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    @(posedge clk); #1;
  endtask

  task automatic hold_test();
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      while (!tx_ready) @(negedge clk);
    end
    rx_ready = 1'b0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      chk(rx_valid == 1'b1, "R10", "capture held while not ready", int'(rx_valid), 1);
    end
    @(posedge clk); #1 rx_ready = 1'b1;
  endtask

  task automatic run_all();
    int cf[8] = '{0, 1, 2, 2, 0, 1, 2, 3};
    int cr[8] = '{3, 0, 1, 2, 0, 3, 3, 2};
    int cq[8] = '{0, 1, 0, 1, 1, 0, 1, 0};
    for (int c = 0; c < 8; c++) begin
      rst_n = 1'b0; tx_valid = 1'b0;
      fmt = 2'(cf[c]); res = 2'(cr[c]); ratio = 1'(cq[c]);
      cur_fmt = cf[c];
      n_bits = (cr[c] == 0) ? 16 : (cr[c] == 1) ? 18 : (cr[c] == 2) ? 20 : 24;
      div = cq[c] ? 6 : 4;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk({bclk, lrclk, sdout, tx_ready, underrun, rx_valid} == 6'b0, "R11",
          "outputs in reset", int'({bclk, lrclk, sdout, tx_ready, underrun, rx_valid}), 0);
      @(posedge clk); #1 rst_n = 1'b1;
      fork
        begin
          for (int f = 0; f < 8; f++) begin
            if (f == 3 || (f == 4 && c % 2 == 1)) idle_frame();
            else send(24'((c * 8 + f) * 32'h00A5C3 + 32'h3C0F1),
                      24'(((c * 8 + f) * 32'h1F3D5) ^ 32'hF0F0F0));
          end
        end
        begin
          if (c == 2) hold_test();
        end
      join
      idle_frame();
      idle_frame();
    end
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (200000) @(posedge clk);
        chk(0, "R1", "watchdog expired", 0, 1);
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule